// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronization

This block is the timing backbone of a pulse-width modulation channel. A 16-bit counter runs between zero and a programmed period, counting up, counting down, or alternating, and advances only on a clock enable. The enable comes from a two-stage prescaler made as a clock-enable generator. The outputs give the current count value, a strobe while the count is zero, and a strobe while it equals the period. Later stages (comparators, waveform logic) build on these.

A synchronization event loads a programmed phase value into the counter. This lets several channels be aligned to one another. In the alternating mode, a control bit chooses the direction that counting resumes in after the load. The event comes from an external sync input or from a one-shot software pulse. A selectable sync output passes a chosen event on to the next channel in a chain. A debug-halt input can freeze counting under a chosen policy, so that a paused system leaves the waveform in a known place.

Configuration uses a simple register port with write enable, 2-bit address and 16-bit data, and a combinational read.

- Address 0 is control: bits [1:0] count mode, bit 2 direction after sync, bits [4:3] sync-output select, bit 5 software sync, bits [7:6] halt policy, bits [10:8] first prescale code, bits [13:11] second prescale code.
- Address 1 is the period.
- Address 2 is the phase.
- Address 3 reads back the count and ignores writes.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the period and phase read 0, and the control reads 0x0800: up mode, first prescale code 0, second prescale code 1.
- R2: The count advances once every A×B system cycles. A is 2 to the power of the first prescale code (1 to 128). B is 1 for second code 0 and twice the code otherwise (2 to 14).
- R3: Any write to the control register restarts the prescaler. The first step after the write falls A×B cycles after it.
- R4: Mode 0 (up) wraps from the period value to 0. Mode 1 (down) reloads the period value after 0. Mode 3 holds the count.
- R5: Mode 2 (up-down) turns downward at the period value and upward at 0.
- R6: A sync event loads the phase value on the next edge, overriding any count step on that edge. In mode 2, counting then goes up if control bit 2 is 1 and down if it is 0. That bit has no effect in the other modes.
- R7: Writing 1 to control bit 5 gives a single one-cycle sync pulse in the cycle after the write. The pulse is ORed with the sync input and acts only when sync-output select is 0. Bit 5 always reads 0.
- R8: The sync output follows the select code. Code 0 gives the combined sync event, code 1 gives count equal to zero, code 2 gives count equal to the compare-B input, and code 3 gives a constant low.
- R9: zeroStb is high exactly while the count is 0, and periodStb is high exactly while the count equals the period value.
- R10: While debug halt is high, halt policy 0 allows one more count step and then freezes. Policy 1 freezes once the count reaches the end of a cycle: the period value in mode 0, zero in modes 1 and 2. Policies 2 and 3 keep counting.
- R11: A sync event during a debug halt still loads the phase value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Register write enable |
| cfgAddr | input | 2 | Register address |
| cfgWdata | input | 16 | Register write data |
| cfgRdata | output | 16 | Register read data (combinational) |
| syncIn | input | 1 | External synchronization input |
| dbgHalt | input | 1 | Debug halt request |
| cmpB | input | 16 | Compare-B value for sync output code 2 |
| syncOut | output | 1 | Selected synchronization output |
| zeroStb | output | 1 | High while count is zero |
| periodStb | output | 1 | High while count equals period |
| count | output | 16 | Current counter value |

## Verification
The count value and all register contents change on the first clock edge after the stimulus that drives them. The sync output, both strobes and read data are combinational in the current cycle. A software sync written on one edge becomes an event in the following cycle, and acts on the count one edge after that. The bench drives inputs on the falling edge. It checks the combinational results shortly after the inputs settle, steps its model across the rising edge, and compares the count at the next falling edge, so each check is made in the cycle in which its result is due.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int DIV_W   = 3;
  localparam int MAX_A   = 1 << ((1 << DIV_W) - 1);
  localparam int MAX_B   = 2 * ((1 << DIV_W) - 1);
  localparam int PRE_W   = $clog2(MAX_A * MAX_B + 1);

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_HOLD   = 2'd3
  } cntMode_e;

  typedef struct packed {
    logic [DIV_W-1:0] divB;
    logic [DIV_W-1:0] divA;
    logic [1:0]       haltPol;
    logic [1:0]       syncSel;
    logic             dirAfterSync;
    cntMode_e         mode;
  } ctlCfg_t;

  typedef struct packed {
    logic load;
    logic step;
    logic loadDirUp;
  } cntStb_t;
endpackage

// File: rtl/ptb_ctrl.sv
module ptb_ctrl
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgWdata,
  output logic [CNT_W-1:0] cfgRdata,
  input  logic             syncIn,
  input  logic             dbgHalt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             isZero,
  input  logic             isPeriod,
  input  logic             isCmpB,
  output ctlCfg_t          cfg,
  output logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] phaseVal,
  output cntStb_t          stb,
  output logic             syncOut
);
  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_PRD = 2'd1;
  localparam logic [1:0] ADDR_PHS = 2'd2;
  localparam int MODE_LSB = 0;
  localparam int DIR_BIT  = 2;
  localparam int SEL_LSB  = 3;
  localparam int SW_BIT   = 5;
  localparam int POL_LSB  = 6;
  localparam int DIVA_LSB = 8;
  localparam int DIVB_LSB = DIVA_LSB + DIV_W;

  logic ctlWr;
  logic swPulse;
  logic frozen;
  logic [PRE_W-1:0] preCnt, divAVal, divBVal, total;
  logic tick, syncEvt, atEnd, haltBlock;

  assign ctlWr = cfgWe && (cfgAddr == ADDR_CTL);

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.mode         <= MODE_UP;
      cfg.dirAfterSync <= 1'b0;
      cfg.syncSel      <= 2'd0;
      cfg.haltPol      <= 2'd0;
      cfg.divA         <= '0;
      cfg.divB         <= DIV_W'(1);
      periodVal        <= '0;
      phaseVal         <= '0;
      swPulse          <= 1'b0;
    end else begin
      swPulse <= ctlWr && cfgWdata[SW_BIT];
      if (ctlWr) begin
        cfg.mode         <= cntMode_e'(cfgWdata[MODE_LSB +: 2]);
        cfg.dirAfterSync <= cfgWdata[DIR_BIT];
        cfg.syncSel      <= cfgWdata[SEL_LSB +: 2];
        cfg.haltPol      <= cfgWdata[POL_LSB +: 2];
        cfg.divA         <= cfgWdata[DIVA_LSB +: DIV_W];
        cfg.divB         <= cfgWdata[DIVB_LSB +: DIV_W];
      end
      if (cfgWe && cfgAddr == ADDR_PRD) periodVal <= cfgWdata;
      if (cfgWe && cfgAddr == ADDR_PHS) phaseVal  <= cfgWdata;
    end
  end

  always_comb begin
    cfgRdata = '0;
    unique case (cfgAddr)
      ADDR_CTL: begin
        cfgRdata[MODE_LSB +: 2]     = cfg.mode;
        cfgRdata[DIR_BIT]           = cfg.dirAfterSync;
        cfgRdata[SEL_LSB +: 2]      = cfg.syncSel;
        cfgRdata[POL_LSB +: 2]      = cfg.haltPol;
        cfgRdata[DIVA_LSB +: DIV_W] = cfg.divA;
        cfgRdata[DIVB_LSB +: DIV_W] = cfg.divB;
      end
      ADDR_PRD: cfgRdata = periodVal;
      ADDR_PHS: cfgRdata = phaseVal;
      default:  cfgRdata = cnt;
    endcase
  end

  // two-stage prescaler as a clock-enable generator
  always_comb begin
    divAVal = PRE_W'(1) << cfg.divA;
    divBVal = (cfg.divB == '0) ? PRE_W'(1) : PRE_W'({cfg.divB, 1'b0});
    total   = PRE_W'(divAVal * divBVal);
    tick    = (preCnt == total - PRE_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preCnt <= '0;
    else if (ctlWr) preCnt <= '0;
    else if (tick)  preCnt <= '0;
    else            preCnt <= preCnt + PRE_W'(1);
  end

  // sync and halt control
  always_comb begin
    syncEvt   = syncIn || (swPulse && cfg.syncSel == 2'd0);
    atEnd     = (cfg.mode == MODE_UP) ? isPeriod : isZero;
    haltBlock = dbgHalt && ((cfg.haltPol == 2'd0 && frozen) ||
                            (cfg.haltPol == 2'd1 && atEnd));
    stb.load      = syncEvt;
    stb.loadDirUp = cfg.dirAfterSync;
    stb.step      = tick && !syncEvt && (cfg.mode != MODE_HOLD) && !haltBlock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frozen <= 1'b0;
    else       frozen <= dbgHalt && (frozen || stb.step);
  end

  always_comb begin
    unique case (cfg.syncSel)
      2'd0:    syncOut = syncEvt;
      2'd1:    syncOut = isZero;
      2'd2:    syncOut = isCmpB;
      default: syncOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptb_datapath.sv
module ptb_datapath
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStb_t          stb,
  input  cntMode_e         mode,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] phaseVal,
  input  logic [CNT_W-1:0] cmpB,
  output logic [CNT_W-1:0] cnt,
  output logic             isZero,
  output logic             isPeriod,
  output logic             isCmpB
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic dirUp;

  assign isZero   = (cnt == '0);
  assign isPeriod = (cnt == periodVal);
  assign isCmpB   = (cnt == cmpB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else if (stb.load) begin
      cnt <= phaseVal;
      if (mode == MODE_UPDOWN) dirUp <= stb.loadDirUp;
    end else if (stb.step) begin
      unique case (mode)
        MODE_UP:   cnt <= isPeriod ? '0 : cnt + ONE;
        MODE_DOWN: cnt <= isZero ? periodVal : cnt - ONE;
        MODE_UPDOWN: begin
          if (dirUp) begin
            if (cnt >= periodVal) begin
              dirUp <= 1'b0;
              if (!isZero) cnt <= cnt - ONE;
            end else begin
              cnt <= cnt + ONE;
            end
          end else begin
            if (isZero) begin
              dirUp <= 1'b1;
              if (periodVal != '0) cnt <= ONE;
            end else begin
              cnt <= cnt - ONE;
            end
          end
        end
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgWdata,
  output logic [CNT_W-1:0] cfgRdata,
  input  logic             syncIn,
  input  logic             dbgHalt,
  input  logic [CNT_W-1:0] cmpB,
  output logic             syncOut,
  output logic             zeroStb,
  output logic             periodStb,
  output logic [CNT_W-1:0] count
);
  ctlCfg_t          cfg;
  cntStb_t          stb;
  logic [CNT_W-1:0] periodVal, phaseVal;
  logic             isZero, isPeriod, isCmpB;

  ptb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .syncIn(syncIn),
    .dbgHalt(dbgHalt), .cnt(count), .isZero(isZero), .isPeriod(isPeriod),
    .isCmpB(isCmpB), .cfg(cfg), .periodVal(periodVal), .phaseVal(phaseVal),
    .stb(stb), .syncOut(syncOut)
  );

  ptb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(cfg.mode),
    .periodVal(periodVal), .phaseVal(phaseVal), .cmpB(cmpB),
    .cnt(count), .isZero(isZero), .isPeriod(isPeriod), .isCmpB(isCmpB)
  );

  assign zeroStb   = isZero;
  assign periodStb = isPeriod;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic [1:0]       syncSel,
  input logic [1:0]       haltPol,
  input logic             dbgHalt,
  input logic             syncIn,
  input logic             load,
  input logic             step,
  input logic             syncOut,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] periodVal,
  input logic [CNT_W-1:0] phaseVal
);
  // R4: up mode returns to zero after a step taken at the period value
  a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && step && cnt == periodVal) |=> (cnt == '0));

  // R4: hold mode keeps the count unless a sync loads it
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && !load) |=> (cnt == $past(cnt)));

  // R6: an external sync loads the phase value on the next edge
  a_r6_sync_load: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (cnt == $past(phaseVal)));

  // R8: select code 3 keeps the sync output low
  a_r8_sync_off: assert property (@(posedge clk) disable iff (!rstN)
    (syncSel == 2'd3) |-> !syncOut);

  // R10: end-of-cycle halt keeps an up counter parked at the period value
  a_r10_end_halt: assert property (@(posedge clk) disable iff (!rstN)
    (dbgHalt && haltPol == 2'd1 && mode == 2'd0 && cnt == periodVal && !load)
      |=> (cnt == $past(cnt)));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .mode(cfg.mode), .syncSel(cfg.syncSel),
  .haltPol(cfg.haltPol), .dbgHalt(dbgHalt), .syncIn(syncIn),
  .load(stb.load), .step(stb.step), .syncOut(syncOut), .cnt(count),
  .periodVal(periodVal), .phaseVal(phaseVal)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic        syncIn = 1'b0;
  logic        dbgHalt = 1'b0;
  logic [15:0] cmpB = '0;
  logic        syncOut, zeroStb, periodStb;
  logic [15:0] count;

  int nChecks = 0;
  int nErrors = 0;
  string curReq = "R1";

  // reference model state
  logic [15:0] mCtl, mPrd, mPhs, mCnt;
  bit mDir, mFrozen, mSw;
  int mPre;

  pwm_timebase dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .syncIn(syncIn),
    .dbgHalt(dbgHalt), .cmpB(cmpB), .syncOut(syncOut), .zeroStb(zeroStb),
    .periodStb(periodStb), .count(count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int divTotal(logic [15:0] c);
    int a, b;
    a = 1 << c[10:8];
    b = (c[13:11] == 3'd0) ? 1 : 2 * int'(c[13:11]);
    return a * b;
  endfunction

  function automatic logic [15:0] mkCtl(int mode, int dir, int sel, int sw,
                                        int pol, int dA, int dB);
    return 16'((mode & 3) | ((dir & 1) << 2) | ((sel & 3) << 3) | ((sw & 1) << 5) |
               ((pol & 3) << 6) | ((dA & 7) << 8) | ((dB & 7) << 11));
  endfunction

  // one cycle: inputs already driven at the falling edge
  task automatic cyc();
    int mode, sel, pol;
    bit tk, sy, atEnd, blk, st, expSync;
    logic [15:0] expRd, nCnt;
    bit nDir;
    #1;
    mode = int'(mCtl[1:0]);
    sel  = int'(mCtl[4:3]);
    pol  = int'(mCtl[7:6]);
    tk   = (mPre == divTotal(mCtl) - 1);
    sy   = syncIn || (mSw && sel == 0);
    atEnd = (mode == 0) ? (mCnt == mPrd) : (mCnt == 16'd0);
    blk  = dbgHalt && ((pol == 0 && mFrozen) || (pol == 1 && atEnd));
    st   = tk && !sy && mode != 3 && !blk;
    case (sel)
      0: expSync = sy;
      1: expSync = (mCnt == 16'd0);
      2: expSync = (mCnt == cmpB);
      default: expSync = 1'b0;
    endcase
    case (cfgAddr)
      2'd0: expRd = mCtl;
      2'd1: expRd = mPrd;
      2'd2: expRd = mPhs;
      default: expRd = mCnt;
    endcase
    chk(curReq, "syncOut (R8)", 16'(syncOut), 16'(expSync));
    chk(curReq, "zeroStb (R9)", 16'(zeroStb), 16'(mCnt == 16'd0));
    chk(curReq, "periodStb (R9)", 16'(periodStb), 16'(mCnt == mPrd));
    chk(curReq, "readback", cfgRdata, expRd);
    // next state
    nCnt = mCnt; nDir = mDir;
    if (sy) begin
      nCnt = mPhs;
      if (mode == 2) nDir = mCtl[2];
    end else if (st) begin
      if (mode == 0) nCnt = (mCnt == mPrd) ? 16'd0 : mCnt + 16'd1;
      else if (mode == 1) nCnt = (mCnt == 16'd0) ? mPrd : mCnt - 16'd1;
      else if (mode == 2) begin
        if (mDir) begin
          if (mCnt >= mPrd) begin
            nDir = 1'b0;
            if (mCnt != 16'd0) nCnt = mCnt - 16'd1;
          end else nCnt = mCnt + 16'd1;
        end else begin
          if (mCnt == 16'd0) begin
            nDir = 1'b1;
            if (mPrd != 16'd0) nCnt = 16'd1;
          end else nCnt = mCnt - 16'd1;
        end
      end
    end
    mFrozen = dbgHalt && (mFrozen || st);
    if (cfgWe && cfgAddr == 2'd0) mPre = 0;
    else if (tk) mPre = 0;
    else mPre = mPre + 1;
    mSw = cfgWe && cfgAddr == 2'd0 && cfgWdata[5];
    if (cfgWe && cfgAddr == 2'd0) mCtl = cfgWdata & 16'h3FDF;
    if (cfgWe && cfgAddr == 2'd1) mPrd = cfgWdata;
    if (cfgWe && cfgAddr == 2'd2) mPhs = cfgWdata;
    mCnt = nCnt; mDir = nDir;
    @(negedge clk);
    chk(curReq, "count", count, mCnt);
  endtask

  task automatic run(int n);
    repeat (n) cyc();
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    cyc();
    cfgWe = 1'b0; cfgAddr = 2'd3;
  endtask

  task automatic pulseSync();
    syncIn = 1'b1; cyc(); syncIn = 1'b0;
  endtask

  initial begin
    mCtl = 16'h0800; mPrd = '0; mPhs = '0; mCnt = '0;
    mDir = 1'b1; mFrozen = 1'b0; mSw = 1'b0; mPre = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    curReq = "R1";
    chk("R1", "count at reset", count, 16'd0);
    cfgAddr = 2'd0; cyc();
    chk("R1", "control reset", cfgRdata, 16'h0800);
    cfgAddr = 2'd1; cyc();
    chk("R1", "period reset", cfgRdata, 16'd0);
    cfgAddr = 2'd2; cyc();

    // R2: prescale 2*4 = 8 cycles per step in up mode
    curReq = "R2";
    wr(2'd1, 16'd50);
    wr(2'd0, mkCtl(0, 0, 3, 0, 2, 1, 2));
    run(40);
    chk("R2", "count after 40 cycles at /8", count, 16'd5);
    wr(2'd0, mkCtl(0, 0, 3, 0, 2, 3, 7));
    run(200);

    // R3: control rewrites restart the prescaler
    curReq = "R3";
    wr(2'd0, mkCtl(0, 0, 3, 0, 2, 1, 2));
    run(5);
    wr(2'd0, mkCtl(0, 0, 3, 0, 2, 1, 2));
    run(5);
    wr(2'd0, mkCtl(0, 0, 3, 0, 2, 1, 2));
    run(30);

    // R4: up wrap, down reload, hold
    curReq = "R4";
    wr(2'd1, 16'd5);
    wr(2'd0, mkCtl(0, 0, 1, 0, 2, 0, 0));
    run(20);
    wr(2'd0, mkCtl(1, 0, 1, 0, 2, 0, 0));
    run(20);
    wr(2'd0, mkCtl(3, 0, 1, 0, 2, 0, 0));
    run(6);

    // R5: up-down reversal
    curReq = "R5";
    wr(2'd1, 16'd4);
    wr(2'd0, mkCtl(2, 0, 1, 0, 2, 0, 0));
    run(24);

    // R6: phase load with forced direction
    curReq = "R6";
    wr(2'd2, 16'd2);
    wr(2'd0, mkCtl(2, 1, 1, 0, 2, 0, 0));
    run(3); pulseSync(); run(4);
    wr(2'd0, mkCtl(2, 0, 1, 0, 2, 0, 0));
    run(3); pulseSync(); run(4);
    wr(2'd0, mkCtl(0, 0, 1, 0, 2, 0, 0));
    run(2); pulseSync();
    chk("R6", "load beats step", count, 16'd2);
    run(3);

    // R7: software sync
    curReq = "R7";
    wr(2'd2, 16'd3);
    wr(2'd0, mkCtl(0, 0, 0, 1, 2, 0, 1));
    cfgAddr = 2'd0; cyc();
    chk("R7", "sw sync bit reads 0", cfgRdata & 16'h0020, 16'd0);
    run(4);
    wr(2'd0, mkCtl(0, 0, 1, 1, 2, 0, 1));
    run(6);

    // R8: sync output select codes
    curReq = "R8";
    cmpB = 16'd3;
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, mkCtl(0, 0, s, 0, 2, 0, 0));
      run(3); pulseSync(); run(8);
    end

    // R9: strobes across a period
    curReq = "R9";
    wr(2'd1, 16'd6);
    run(14);

    // R10: halt policies
    curReq = "R10";
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 3; m++) begin
        wr(2'd0, mkCtl(m, 1, 1, 0, p, 0, 1));
        run(3);
        dbgHalt = 1'b1; run(20);
        dbgHalt = 1'b0; run(4);
      end
    end

    // R11: sync during halt
    curReq = "R11";
    wr(2'd2, 16'd4);
    wr(2'd0, mkCtl(0, 0, 1, 0, 0, 0, 0));
    dbgHalt = 1'b1; run(4);
    pulseSync();
    chk("R11", "phase loaded while halted", count, 16'd4);
    run(4);
    dbgHalt = 1'b0; run(3);

    // constrained random mix
    curReq = "R2";
    for (int i = 0; i < 4000; i++) begin
      int r;
      curReq = (i % 2 == 0) ? "R4" : "R5";
      syncIn = ($urandom % 40) == 0;
      if (($urandom % 25) == 0) dbgHalt = ~dbgHalt;
      if (($urandom % 10) == 0) cmpB = 16'($urandom % 13);
      r = $urandom % 30;
      if (r == 0) begin
        cfgWe = 1'b1; cfgAddr = 2'd0;
        cfgWdata = mkCtl($urandom % 4, $urandom % 2, $urandom % 4, $urandom % 2,
                         $urandom % 4, $urandom % 3, $urandom % 3);
      end else if (r == 1) begin
        cfgWe = 1'b1; cfgAddr = 2'd1; cfgWdata = 16'($urandom % 13);
      end else if (r == 2) begin
        cfgWe = 1'b1; cfgAddr = 2'd2; cfgWdata = 16'($urandom % 16);
      end else if (r == 3) begin
        cfgWe = 1'b1; cfgAddr = 2'd3; cfgWdata = 16'($urandom);
      end else begin
        cfgWe = 1'b0; cfgAddr = 2'($urandom % 4);
      end
      cyc();
    end
    cfgWe = 1'b0; syncIn = 1'b0; dbgHalt = 1'b0;

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule